// File: doc/BRIEF.md
# Multi-Lane Universal Hash Index Generator

This block turns a signature word, made of six equal-width fields, into one 8-bit array index per hash lane. Every input bit owns a fixed random key word for each lane. The bit gates its key word, and the lane's index is the XOR of all the gated words. The hash uses no adders or multipliers: one AND level and one XOR reduction per lane. Because each key word lies in 0..m-1 with m = 256, every index addresses an entry of a 256-entry counter array.

Several lanes run side by side, each with its own key set, so one signature yields several independent indices for a multi-hash membership filter. The key sets are elaboration parameters. A package supplies a default pseudo-random pool, and an integrator can override the whole key vector. The indices are registered. A signature presented with `in_valid` high gives its indices, with `out_valid` high, on the next cycle. While `in_valid` is low, the registered indices hold their value.

Top module: `sig_hash_bank`

## Requirements
- R1: While `rst_n` is low and after reset, `out_valid` is 0 and every lane index is 0 until the first accepted signature.
- R2: `out_valid` equals the `in_valid` value sampled at the previous rising clock edge.
- R3: The index of lane j is the XOR, over every set bit i of `sig_fields`, of key word (j,i). Key word (j,i) is `KEYS[(j*IN_W+i)*IDX_W +: IDX_W]`, with IN_W = NUM_FIELDS*FIELD_W. Field k occupies `sig_fields[k*FIELD_W +: FIELD_W]`. Lane j is presented on `out_index[j*IDX_W +: IDX_W]`.
- R4: An all-zero signature gives index 0 on every lane, whatever index was held before.
- R5: A signature with exactly one set bit i gives, on lane j, exactly key word (j,i).
- R6: The hash is linear over XOR: for signatures a and b, index(a XOR b) = index(a) XOR index(b) on every lane.
- R7: While `in_valid` is low, every lane index keeps its previous value, whatever `sig_fields` carries.
- R8: Each lane uses only its own key set. For a bit whose key words differ between two lanes, the two lanes give different indices for the same signature.
- R9: With `in_valid` high on consecutive cycles, a new correct set of indices appears on every cycle, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Signature on `sig_fields` is to be hashed |
| sig_fields | input | NUM_FIELDS*FIELD_W | Signature word, six fields of FIELD_W bits by default |
| out_valid | output | 1 | Indices on `out_index` belong to a signature accepted last cycle |
| out_index | output | NUM_HASH*IDX_W | One IDX_W-bit index per lane, lane 0 in the low bits |

## Verification
On every cycle, the bound checker enforces the one-cycle valid latency, the hold of all indices when no signature is accepted, the zero result for an all-zero signature, and the single-bit-equals-key rule on every lane. The full XOR-of-gated-keys mapping for arbitrary signatures is shown only by the bench's scenarios. These compare against a model built from a key table of the bench's own. The same applies to linearity across three signatures, lane independence and continuous back-to-back throughput.

// File: rtl/ushash_pkg.sv
package ushash_pkg;

    localparam int POOL_W = 2048;

    // Pseudo-random bit pool used as the default key material.
    function automatic logic [POOL_W-1:0] build_pool();
        logic [POOL_W-1:0] pool;
        logic [31:0]       s;
        pool = '0;
        s    = 32'h9E37_79B9;
        for (int w = 0; w < POOL_W / 8; w++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            pool[w*8 +: 8] = s[7:0] ^ s[15:8];
        end
        return pool;
    endfunction

    localparam logic [POOL_W-1:0] KEY_POOL = build_pool();

endpackage

// File: rtl/ushash_fold.sv
module ushash_fold #(
    parameter int IN_W  = 48,
    parameter int IDX_W = 8,
    parameter logic [IN_W*IDX_W-1:0] KEYS = '0
) (
    input  logic [IN_W-1:0]  din,
    output logic [IDX_W-1:0] hash
);

    logic [IDX_W-1:0] gated [IN_W];

    // One AND gate row per input bit: the bit selects its key word.
    for (genvar b = 0; b < IN_W; b++) begin : g_gate
        assign gated[b] = KEYS[b*IDX_W +: IDX_W] & {IDX_W{din[b]}};
    end

    always_comb begin
        hash = '0;
        for (int b = 0; b < IN_W; b++) begin
            hash = hash ^ gated[b];
        end
    end

endmodule

// File: rtl/ushash_lane.sv
module ushash_lane #(
    parameter int IN_W  = 48,
    parameter int IDX_W = 8,
    parameter logic [IN_W*IDX_W-1:0] KEYS = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IN_W-1:0]  din,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] hash_d;

    ushash_fold #(
        .IN_W (IN_W),
        .IDX_W(IDX_W),
        .KEYS (KEYS)
    ) u_fold (
        .din (din),
        .hash(hash_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (load) begin
            idx <= hash_d;
        end
    end

endmodule

// File: rtl/sig_hash_bank.sv
module sig_hash_bank
    import ushash_pkg::*;
#(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8,
    parameter int IDX_W      = 8,
    parameter int NUM_HASH   = 3,
    parameter logic [NUM_HASH*NUM_FIELDS*FIELD_W*IDX_W-1:0] KEYS =
        KEY_POOL[NUM_HASH*NUM_FIELDS*FIELD_W*IDX_W-1:0]
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [NUM_FIELDS*FIELD_W-1:0] sig_fields,
    output logic                         out_valid,
    output logic [NUM_HASH*IDX_W-1:0]    out_index
);

    localparam int IN_W     = NUM_FIELDS * FIELD_W;
    localparam int LANE_KEY = IN_W * IDX_W;

    for (genvar j = 0; j < NUM_HASH; j++) begin : g_lane
        ushash_lane #(
            .IN_W (IN_W),
            .IDX_W(IDX_W),
            .KEYS (KEYS[j*LANE_KEY +: LANE_KEY])
        ) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .load (in_valid),
            .din  (sig_fields),
            .idx  (out_index[j*IDX_W +: IDX_W])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

endmodule

// File: rtl/ushash_check.sv
module ushash_check #(
    parameter int NUM_FIELDS = 6,
    parameter int FIELD_W    = 8,
    parameter int IDX_W      = 8,
    parameter int NUM_HASH   = 3,
    parameter logic [NUM_HASH*NUM_FIELDS*FIELD_W*IDX_W-1:0] KEYS = '0
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [NUM_FIELDS*FIELD_W-1:0] sig_fields,
    input logic                          out_valid,
    input logic [NUM_HASH*IDX_W-1:0]     out_index
);

    localparam int IN_W = NUM_FIELDS * FIELD_W;
    localparam int HW   = $clog2(IN_W);

    logic          seen;
    logic [HW-1:0] hot;
    logic [HW-1:0] hot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else begin
            seen <= 1'b1;
        end
    end

    always_comb begin
        hot = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (sig_fields[i]) hot = HW'(i);
        end
    end

    always_ff @(posedge clk) begin
        hot_q <= hot;
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (out_valid == $past(in_valid)));

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && !$past(in_valid)) |-> $stable(out_index));

    assert_zero_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (sig_fields == '0)) |=> (out_index == '0));

    for (genvar j = 0; j < NUM_HASH; j++) begin : g_lane_chk
        assert_single_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && $onehot(sig_fields)) |=>
            (out_index[j*IDX_W +: IDX_W] == KEYS[(j*IN_W + int'(hot_q))*IDX_W +: IDX_W]));
    end

endmodule

bind sig_hash_bank ushash_check #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W),
    .IDX_W     (IDX_W),
    .NUM_HASH  (NUM_HASH),
    .KEYS      (KEYS)
) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sig_fields(sig_fields),
    .out_valid (out_valid),
    .out_index (out_index)
);

// File: tb/sig_hash_bank_test.sv
module sig_hash_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 8;
    localparam int IDX_W      = 8;
    localparam int NUM_HASH   = 3;
    localparam int IN_W       = NUM_FIELDS * FIELD_W;
    localparam int KEY_W      = NUM_HASH * IN_W * IDX_W;
    localparam int MAX_CYCLES = 20000;

    // Bench-owned key table from a linear congruential sequence.
    function automatic logic [KEY_W-1:0] make_keys();
        logic [KEY_W-1:0] k;
        logic [31:0]      s;
        k = '0;
        s = 32'hC0FF_EE11;
        for (int w = 0; w < NUM_HASH * IN_W; w++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            k[w*IDX_W +: IDX_W] = s[31:24];
        end
        return k;
    endfunction

    localparam logic [KEY_W-1:0] BK = make_keys();

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic [IN_W-1:0]           sig_fields = '0;
    logic                      out_valid;
    logic [NUM_HASH*IDX_W-1:0] out_index;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic             exp_v;
    logic [IDX_W-1:0] exp_idx [NUM_HASH];
    string            pend_tag;

    sig_hash_bank #(
        .NUM_FIELDS(NUM_FIELDS),
        .FIELD_W   (FIELD_W),
        .IDX_W     (IDX_W),
        .NUM_HASH  (NUM_HASH),
        .KEYS      (BK)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sig_fields(sig_fields),
        .out_valid (out_valid),
        .out_index (out_index)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [IDX_W-1:0] key_of(int j, int i);
        return BK[(j*IN_W + i)*IDX_W +: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] model(int j, logic [IN_W-1:0] d);
        logic [IDX_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (d[i]) acc = acc ^ key_of(j, i);
        end
        return acc;
    endfunction

    function automatic logic [IDX_W-1:0] lane(int j);
        return out_index[j*IDX_W +: IDX_W];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // At a falling edge: check the result of the previous drive, then drive.
    task automatic step(logic v, logic [IN_W-1:0] d, string tag);
        @(negedge clk);
        chk("R2 valid", 32'(out_valid), 32'(exp_v));
        for (int j = 0; j < NUM_HASH; j++) begin
            chk($sformatf("%s lane%0d", pend_tag, j), 32'(lane(j)), 32'(exp_idx[j]));
        end
        in_valid   = v;
        sig_fields = d;
        exp_v      = v;
        pend_tag   = v ? tag : "R7 hold";
        if (v) begin
            for (int j = 0; j < NUM_HASH; j++) exp_idx[j] = model(j, d);
        end
    endtask

    function automatic logic [IN_W-1:0] rnd_sig();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[IN_W-1:0];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [IN_W-1:0]  a;
        logic [IN_W-1:0]  b;
        logic [IDX_W-1:0] ha [NUM_HASH];
        logic [IDX_W-1:0] hb [NUM_HASH];
        int               diff_bit;
        void'($urandom(32'd2024));
        exp_v    = 1'b0;
        pend_tag = "R1 reset";
        for (int j = 0; j < NUM_HASH; j++) exp_idx[j] = '0;

        // R1: reset state, with a signature present on the inputs
        sig_fields = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 valid in reset", 32'(out_valid), 32'd0);
        chk("R1 index in reset", 32'(out_index), 32'd0);
        rst_n = 1'b1;
        sig_fields = '0;

        step(1'b0, '0, "R1");
        // R7: idle with non-zero data must not load
        step(1'b0, rnd_sig(), "R7");
        step(1'b0, rnd_sig(), "R7");

        // R3: a few directed field patterns
        step(1'b1, {IN_W{1'b1}}, "R3 all-ones");
        step(1'b1, {{(IN_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}}, "R3 first field");
        step(1'b1, {{FIELD_W{1'b1}}, {(IN_W-FIELD_W){1'b0}}}, "R3 last field");

        // R4: zero after a non-zero result
        step(1'b1, '0, "R4 zero");

        // R5: every single-bit signature
        for (int i = 0; i < IN_W; i++) begin
            step(1'b1, IN_W'(1) << i, "R5 single bit");
        end

        // R6: linearity, using observed outputs
        a = rnd_sig();
        b = rnd_sig();
        step(1'b1, a, "R6 a");
        step(1'b0, a, "R6");
        for (int j = 0; j < NUM_HASH; j++) ha[j] = lane(j);
        step(1'b1, b, "R6 b");
        step(1'b0, b, "R6");
        for (int j = 0; j < NUM_HASH; j++) hb[j] = lane(j);
        step(1'b1, a ^ b, "R6 a^b");
        step(1'b0, a, "R6");
        for (int j = 0; j < NUM_HASH; j++) begin
            chk("R6 linearity", 32'(lane(j)), 32'(ha[j] ^ hb[j]));
        end

        // R8: lanes 0 and 1 on a bit whose keys differ
        diff_bit = 0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            if (key_of(0, i) != key_of(1, i)) diff_bit = i;
        end
        step(1'b1, IN_W'(1) << diff_bit, "R8 lane keys");
        step(1'b0, '0, "R8");
        checks++;
        if (lane(0) == lane(1)) begin
            errors++;
            $display("FAIL R8 independence: actual %h expected differ from %h", lane(1), lane(0));
        end

        // R9: back-to-back stream of random signatures
        for (int n = 0; n < 200; n++) begin
            step(1'b1, rnd_sig(), "R9 stream");
        end

        // R3/R7: random traffic with idle gaps
        for (int n = 0; n < 400; n++) begin
            step(($urandom() % 4) != 0, rnd_sig(), "R3 random");
        end
        step(1'b0, '0, "R7");
        step(1'b0, '0, "R7");

        finish_run();
    end

endmodule